// File: doc/BRIEF.md
# PCM Voice Codec Serial Port

This block is the digital serial side of a telephony voice codec. In each 8 kHz frame it sends one 8-bit companded sample on a transmit data pin and takes one 8-bit sample from a receive data pin. Each direction has its own frame sync and bit clock. The transmit pin is modelled as a data line plus an output enable, so that the pad stays in high impedance outside the slot. An active-low time-slot strobe is low for as long as the transmit slot is being driven. Samples reach the block through a parallel word input and leave it through a parallel word output with a valid pulse.

All pins are sampled in the transmit master clock domain, which is `clk_i`. Two detectors watch the receive master clock pin and the receive bit clock pin for static levels. A receive master clock pin held high puts the block into power-down. Held low, it means the transmit master clock times everything. A receive bit clock pin held at either level selects synchronous mode, in which the transmit bit clock also clocks the receive slot, and the held level reports the master clock frequency class.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst_ni` is low, `tx_oe_o` is 0, `tx_slot_n_o` is 1 and `rx_valid_o` is 0.
- R2: On the first rising transmit bit clock edge with transmit frame sync high, the block latches `tx_word_i` and drives its MSB on `tx_sd_o` with `tx_oe_o` high. Each later rising edge presents the next lower bit, so one slot carries 8 bits MSB first. The block arms only after it has seen transmit frame sync low.
- R3: `tx_slot_n_o` is low in exactly the cycles in which `tx_oe_o` is high.
- R4: The ninth rising edge after slot start drops `tx_oe_o` and raises `tx_slot_n_o`, even while frame sync is still high. No new slot starts until frame sync has gone low and then high again.
- R5: A receive slot starts on a rising receive bit clock edge with receive frame sync high. The next 8 falling edges sample `rx_sd_i`, MSB first.
- R6: In the cycle after the eighth sample, `rx_valid_o` is high for exactly one cycle and `rx_word_o` holds the received byte.
- R7: A watched pin counts as static after 32 consecutive `clk_i` cycles with no edge on it. Any edge clears that status on the next cycle.
- R8: A static high on `rx_mclk_i` sets `pwr_down_o`. In power-down, `tx_oe_o` stays 0, `tx_slot_n_o` stays 1 and no `rx_valid_o` pulse occurs.
- R9: A static low on `rx_mclk_i` sets `mclk_shared_o`. Serial transfers continue unchanged.
- R10: A static `rx_bclk_i` sets `sync_mode_o`. The receive slot is then clocked by `tx_bclk_i`, and `fsel_hi_o` equals the held level, where 1 means the 2.048 MHz class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit master clock, system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_bclk_i | input | 1 | Transmit bit clock pin |
| tx_fs_i | input | 1 | Transmit frame sync pin |
| tx_word_i | input | 8 | Next sample to send |
| tx_sd_o | output | 1 | Transmit serial data |
| tx_oe_o | output | 1 | Transmit pad enable; low means high impedance |
| tx_slot_n_o | output | 1 | Active-low transmit time-slot strobe |
| rx_mclk_i | input | 1 | Receive master clock pin, watched for static level |
| rx_bclk_i | input | 1 | Receive bit clock pin |
| rx_fs_i | input | 1 | Receive frame sync pin |
| rx_sd_i | input | 1 | Receive serial data |
| rx_word_o | output | 8 | Last received sample |
| rx_valid_o | output | 1 | One-cycle pulse when a sample is received |
| pwr_down_o | output | 1 | Power-down active |
| mclk_shared_o | output | 1 | Transmit master clock times both directions |
| sync_mode_o | output | 1 | Synchronous mode, transmit bit clock used for receive |
| fsel_hi_o | output | 1 | Master clock class in sync mode: 1 = 2.048 MHz |

## Verification
The receive word completion and the end of the transmit slot can occur in the same clock cycle. In the asynchronous frames the receive bit clock is offset by half a period, so its eighth falling edge lands on the same `clk_i` edge as the transmit clock's ninth rising edge. The bench then checks, in that one cycle, both the one-cycle valid pulse with the correct byte and the release of the pad enable and time-slot strobe. Randomised bytes and directed runs with a long frame sync, power-down and sync mode cover the rest.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef struct packed {
    logic pwr_down;
    logic mclk_shared;
    logic sync_mode;
    logic fsel_hi;
  } pcm_mode_t;

  function automatic pcm_mode_t decode_mode(input logic mclk_static, input logic mclk_level,
                                            input logic bclk_static, input logic bclk_level);
    pcm_mode_t m;
    m.pwr_down    = mclk_static & mclk_level;
    m.mclk_shared = mclk_static & ~mclk_level;
    m.sync_mode   = bclk_static & ~m.pwr_down;
    m.fsel_hi     = m.sync_mode & bclk_level;
    return m;
  endfunction
endpackage

// File: rtl/pcm_static_det.sv
module pcm_static_det #(
  parameter int WIN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic static_o,
  output logic level_o
);
  localparam int CW = $clog2(WIN + 1);

  logic          pin_q;
  logic [CW-1:0] quiet_q;
  logic          edge_w;

  assign edge_w = pin_i ^ pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q   <= 1'b0;
      quiet_q <= '0;
    end else begin
      pin_q <= pin_i;
      if (edge_w) quiet_q <= '0;
      else if (quiet_q != CW'(WIN)) quiet_q <= quiet_q + 1'b1;
    end
  end

  assign static_o = (quiet_q == CW'(WIN));
  assign level_o  = pin_q;

  // R7: an edge on the pin clears static status on the next cycle
  assert_edge_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_i != pin_q) |=> !static_o);
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bclk_i,
  input  logic         fs_i,
  input  logic [W-1:0] word_i,
  output logic         sd_o,
  output logic         oe_o
);
  localparam int CW = $clog2(W);

  logic          bclk_q, armed_q, active_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          rise_w;

  assign rise_w = bclk_i & ~bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (!en_i) begin
        armed_q  <= 1'b0;
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        if (!fs_i) armed_q <= 1'b1;
        if (rise_w) begin
          if (active_q) begin
            if (cnt_q == CW'(W - 1)) active_q <= 1'b0;
            else begin
              cnt_q <= cnt_q + 1'b1;
              sh_q  <= {sh_q[W-2:0], 1'b0};
            end
          end else if (armed_q && fs_i) begin
            active_q <= 1'b1;
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            sh_q     <= word_i;
          end
        end
      end
    end
  end

  assign sd_o = sh_q[W-1];
  assign oe_o = active_q;

  assert_start_needs_fs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> ($past(fs_i) && $past(armed_q) && $past(rise_w)));
  assert_end_after_last_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> (($past(cnt_q) == CW'(W - 1)) || !$past(en_i)));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bclk_i,
  input  logic         fs_i,
  input  logic         sd_i,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  localparam int CW = $clog2(W);

  logic          bclk_q, armed_q, active_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q, word_q;
  logic          rise_w, fall_w;

  assign rise_w = bclk_i & ~bclk_q;
  assign fall_w = ~bclk_i & bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      armed_q  <= 1'b0;
      active_q <= 1'b0;
      valid_q  <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      word_q   <= '0;
    end else begin
      bclk_q  <= bclk_i;
      valid_q <= 1'b0;
      if (!en_i) begin
        armed_q  <= 1'b0;
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        if (!fs_i) armed_q <= 1'b1;
        if (active_q && fall_w) begin
          sh_q <= {sh_q[W-2:0], sd_i};
          if (cnt_q == CW'(W - 1)) begin
            active_q <= 1'b0;
            valid_q  <= 1'b1;
            word_q   <= {sh_q[W-2:0], sd_i};
          end else cnt_q <= cnt_q + 1'b1;
        end else if (!active_q && rise_w && armed_q && fs_i) begin
          active_q <= 1'b1;
          armed_q  <= 1'b0;
          cnt_q    <= '0;
        end
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  assert_valid_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  assert_valid_from_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> ($past(active_q) && !active_q));
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_pkg::*;
#(
  parameter int SAMPLE_W   = 8,
  parameter int STATIC_WIN = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_bclk_i,
  input  logic                tx_fs_i,
  input  logic [SAMPLE_W-1:0] tx_word_i,
  output logic                tx_sd_o,
  output logic                tx_oe_o,
  output logic                tx_slot_n_o,
  input  logic                rx_mclk_i,
  input  logic                rx_bclk_i,
  input  logic                rx_fs_i,
  input  logic                rx_sd_i,
  output logic [SAMPLE_W-1:0] rx_word_o,
  output logic                rx_valid_o,
  output logic                pwr_down_o,
  output logic                mclk_shared_o,
  output logic                sync_mode_o,
  output logic                fsel_hi_o
);
  localparam int NPIN = 2;

  logic [NPIN-1:0] pins_w, static_w, level_w;
  pcm_mode_t       mode_w;
  logic            rx_clk_w, tx_oe_w;

  assign pins_w = {rx_bclk_i, rx_mclk_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_det
    pcm_static_det #(.WIN(STATIC_WIN)) u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pins_w[g]),
      .static_o(static_w[g]),
      .level_o (level_w[g])
    );
  end

  assign mode_w = decode_mode(static_w[0], level_w[0], static_w[1], level_w[1]);

  // sync mode: transmit bit clock drives the receive slot too
  assign rx_clk_w = mode_w.sync_mode ? tx_bclk_i : rx_bclk_i;

  pcm_tx_slot #(.W(SAMPLE_W)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (~mode_w.pwr_down),
    .bclk_i(tx_bclk_i),
    .fs_i  (tx_fs_i),
    .word_i(tx_word_i),
    .sd_o  (tx_sd_o),
    .oe_o  (tx_oe_w)
  );

  pcm_rx_slot #(.W(SAMPLE_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (~mode_w.pwr_down),
    .bclk_i (rx_clk_w),
    .fs_i   (rx_fs_i),
    .sd_i   (rx_sd_i),
    .word_o (rx_word_o),
    .valid_o(rx_valid_o)
  );

  assign tx_oe_o       = tx_oe_w;
  assign tx_slot_n_o   = ~tx_oe_w;
  assign pwr_down_o    = mode_w.pwr_down;
  assign mclk_shared_o = mode_w.mclk_shared;
  assign sync_mode_o   = mode_w.sync_mode;
  assign fsel_hi_o     = mode_w.fsel_hi;

  assert_pd_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pwr_down_o) && pwr_down_o) |-> (!tx_oe_o && !rx_valid_o));
  assert_modes_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pwr_down_o, mclk_shared_o}));
endmodule

// File: tb/pcm_serial_port_tb_top.sv
module pcm_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_bclk_i = 1'b0, tx_fs_i = 1'b0, rx_mclk_i = 1'b0, rx_bclk_i = 1'b0;
  logic rx_fs_i = 1'b0, rx_sd_i = 1'b0;
  logic [7:0] tx_word_i = '0;
  logic tx_sd_o, tx_oe_o, tx_slot_n_o, rx_valid_o;
  logic pwr_down_o, mclk_shared_o, sync_mode_o, fsel_hi_o;
  logic [7:0] rx_word_o;
  int total = 0, bad = 0, mclk_mode = 0;

  always #5 clk = ~clk;

  pcm_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_bclk_i(tx_bclk_i), .tx_fs_i(tx_fs_i),
    .tx_word_i(tx_word_i), .tx_sd_o(tx_sd_o), .tx_oe_o(tx_oe_o), .tx_slot_n_o(tx_slot_n_o),
    .rx_mclk_i(rx_mclk_i), .rx_bclk_i(rx_bclk_i), .rx_fs_i(rx_fs_i), .rx_sd_i(rx_sd_i),
    .rx_word_o(rx_word_o), .rx_valid_o(rx_valid_o), .pwr_down_o(pwr_down_o),
    .mclk_shared_o(mclk_shared_o), .sync_mode_o(sync_mode_o), .fsel_hi_o(fsel_hi_o)
  );

  // receive master clock pin: 0 toggles, 1 held low, 2 held high
  always @(negedge clk) begin
    if (mclk_mode == 0) rx_mclk_i = ~rx_mclk_i;
    else rx_mclk_i = (mclk_mode == 2);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bit(input logic [7:0] b, input int j);
    return b[7-j];
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] tb, input logic [7:0] rb, input bit sync,
                           input bit fs_long, input bit pd);
    int valid_cnt = 0, oe_cnt = 0, strobe_bad = 0;
    int vstep = sync ? 60 : 64;
    for (int t = 0; t < 100; t++) begin
      int u = t - 16;
      @(negedge clk);
      tx_bclk_i = ((t % 8) < 4);
      if (!sync) rx_bclk_i = (((t + 4) % 8) < 4);
      tx_fs_i = (u >= 0) && (fs_long ? (u < 80) : (u < 8));
      rx_fs_i = tx_fs_i;
      if (t == 0) tx_word_i = tb;
      if (!sync && u >= 4 && ((u - 4) % 8) == 0 && ((u - 4) / 8) < 8) rx_sd_i = exp_bit(rb, (u - 4) / 8);
      if (sync && u >= 0 && (u % 8) == 0 && (u / 8) < 8) rx_sd_i = exp_bit(rb, u / 8);
      @(posedge clk); #1;
      if (rx_valid_o) valid_cnt++;
      if (tx_oe_o) oe_cnt++;
      if (tx_slot_n_o != !tx_oe_o) strobe_bad++;
      if (!pd && u >= 2 && ((u - 2) % 8) == 0 && ((u - 2) / 8) < 8)
        chk(tx_oe_o && tx_sd_o == exp_bit(tb, (u - 2) / 8), "R2", "tx bit",
            {tx_oe_o, tx_sd_o}, {1'b1, exp_bit(tb, (u - 2) / 8)});
      if (!pd && u == vstep)
        chk(rx_valid_o && rx_word_o == rb, "R6", "rx word", {rx_valid_o, rx_word_o}, {1'b1, rb});
      if (!pd && u == 64)
        chk(!tx_oe_o && tx_slot_n_o, "R4", "slot end", {tx_oe_o, tx_slot_n_o}, 1);
      if (!pd && fs_long && u == 78)
        chk(!tx_oe_o && tx_slot_n_o, "R4", "no restart under long fs", {tx_oe_o, tx_slot_n_o}, 1);
    end
    chk(strobe_bad == 0, "R3", "strobe vs enable mismatches", strobe_bad, 0);
    if (pd) begin
      chk(oe_cnt == 0, "R8", "enable cycles in power-down", oe_cnt, 0);
      chk(valid_cnt == 0, "R8", "valid pulses in power-down", valid_cnt, 0);
    end else begin
      chk(oe_cnt == 64, "R2", "enable cycles", oe_cnt, 64);
      chk(valid_cnt == 1, "R5", "valid pulses", valid_cnt, 1);
    end
    tx_fs_i = 1'b0;
    rx_fs_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    idle(4);
    chk(!tx_oe_o && tx_slot_n_o && !rx_valid_o, "R1", "reset outputs",
        {tx_oe_o, tx_slot_n_o, rx_valid_o}, 3'b010);
    rst_ni = 1'b1;
    // directed, then random asynchronous frames
    run_frame(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0);
    run_frame(8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
    run_frame(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) run_frame(8'($urandom), 8'($urandom), 1'b0, 1'b0, 1'b0);
    run_frame(8'h96, 8'h69, 1'b0, 1'b1, 1'b0);
    // R9: static low master clock
    mclk_mode = 1;
    idle(40);
    chk(mclk_shared_o && !pwr_down_o, "R9", "shared clock flag", {mclk_shared_o, pwr_down_o}, 2'b10);
    run_frame(8'h5A, 8'hC3, 1'b0, 1'b0, 1'b0);
    mclk_mode = 0;
    idle(4);
    chk(!mclk_shared_o, "R7", "edge clears static", mclk_shared_o, 0);
    // R8: power-down
    mclk_mode = 2;
    idle(20);
    chk(!pwr_down_o, "R7", "not static before window", pwr_down_o, 0);
    idle(20);
    chk(pwr_down_o, "R8", "power-down flag", pwr_down_o, 1);
    run_frame(8'hAA, 8'h55, 1'b0, 1'b0, 1'b1);
    mclk_mode = 0;
    idle(4);
    chk(!pwr_down_o, "R7", "power-down released", pwr_down_o, 0);
    run_frame(8'($urandom), 8'h81, 1'b0, 1'b0, 1'b0);
    // R10: sync mode via static receive bit clock
    rx_bclk_i = 1'b1;
    idle(40);
    chk(sync_mode_o && fsel_hi_o, "R10", "sync high class", {sync_mode_o, fsel_hi_o}, 2'b11);
    run_frame(8'h12, 8'hE7, 1'b1, 1'b0, 1'b0);
    rx_bclk_i = 1'b0;
    idle(40);
    chk(sync_mode_o && !fsel_hi_o, "R10", "sync low class", {sync_mode_o, fsel_hi_o}, 2'b10);
    run_frame(8'($urandom), 8'($urandom), 1'b1, 1'b0, 1'b0);
    run_frame(8'h7E, 8'h42, 1'b0, 1'b0, 1'b0);
    chk(!sync_mode_o, "R10", "sync left on toggling pin", sync_mode_o, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule